// File: doc/BRIEF.md
# Floating-Tap Receive Decision-Feedback Equalizer Controller

This block drives the digital side of a receive equalizer that cancels channel reflections using symbols the receiver has already decided. Decisions are 2-bit Gray-coded 4-level symbols. They arrive two per clock as an even/odd pair, because the receiver slices on both clock edges. The block keeps a history of these decisions. Each of five taps picks one past symbol, at a delay of 5 to 17 symbols that software chooses per tap, and multiplies that symbol's signed level by the tap's own weight. The result is one signed current code per tap and per lane, which the analog summer at the input pad consumes.

The block also runs a training sequence that aligns the equalizer's output timing. While training is active, every tap emits an alternating low/high pattern in place of weighted decisions. Early/late votes from clock recovery step a saturating delay code. The receive phase code passed through to the data samplers is held frozen for the whole run. Training ends, and a done flag is raised, once a full window of votes leaves the delay code where the window started.

Top module: `dfe_tap_ctrl`

## Requirements
- R1: Each clock shifts both input decisions into the history. The even decision is one symbol older than the odd one. After an edge, the even lane of a tap at delay d uses the symbol decided d-1 symbols before the most recent one, which is the newest odd input.
- R2: The odd lane of a tap at delay d uses the symbol decided d-2 symbols before the most recent one, so both lanes see the same delay relative to their own target symbol.
- R3: Symbol codes map to levels as follows: 00 to -3, 01 to -1, 11 to +1, 10 to +3. Each lane outputs level times weight as a two's complement code of weight width plus 3 bits. Tap k occupies bits [k*10 +: 10] at default parameters.
- R4: Each tap takes its own position field (5 bits at [k*5 +: 5]) and weight field (7-bit unsigned at [k*7 +: 7]). Positions need not be ordered or consecutive.
- R5: A position value below 5 acts as 5, and a value above 17 acts as 17.
- R6: While training is active, every tap outputs minus its weight on the even lane and plus its weight on the odd lane, in place of weighted decisions.
- R7: During training, an early-only vote raises the delay code by one and a late-only vote lowers it by one. The code saturates at 0 and 31. Both or neither asserted counts as no vote. Votes outside training leave the code unchanged.
- R8: While training is inactive, the receive phase output takes the phase input at each edge. While training is active, it holds its value.
- R9: A start pulse while idle begins training and clears done. At every multiple of the window length in votes, the code is compared with the code at the window's start. If they are equal, training stops and done is raised. Otherwise a new window begins. A window length of 0 acts as 1.
- R10: Reset sets the delay code to 16, clears training active, done and the phase output, and fills the history with code 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one even/odd symbol pair per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dec_even_i | input | 2 | Decided even-lane symbol (older of the pair) |
| dec_odd_i | input | 2 | Decided odd-lane symbol (newer of the pair) |
| tap_pos_i | input | 25 | Five 5-bit tap delay fields |
| tap_wt_i | input | 35 | Five 7-bit unsigned tap weights |
| train_start_i | input | 1 | Start a training run |
| train_len_i | input | 8 | Votes per no-change window |
| cdr_early_i | input | 1 | Clock recovery early vote |
| cdr_late_i | input | 1 | Clock recovery late vote |
| cdr_phase_i | input | 6 | Receive phase code from clock recovery |
| eq_even_o | output | 50 | Five signed even-lane current codes |
| eq_odd_o | output | 50 | Five signed odd-lane current codes |
| dly_code_o | output | 5 | Equalizer clock delay code |
| rx_phase_o | output | 6 | Receive phase code to samplers |
| train_active_o | output | 1 | Training in progress |
| train_done_o | output | 1 | Last training run converged |

## Verification
The hardest state to reach is convergence with the delay code pinned at a rail. There, early votes keep arriving but the code cannot move, and the window must still see no net change and finish. The stimulus first trains with a long run of early votes until the code climbs to 31 and holds there. It then trains with alternating late/early votes that return to the window's base value, and finally with late votes down to 0. A final run with a zero window length converges on one saturated vote. Phase inputs keep changing throughout, so that the freeze is visible.

// File: rtl/dfe_pkg.sv
package dfe_pkg;
  typedef logic [1:0] sym_t;

  // Gray symbol to signed level
  function automatic logic signed [2:0] sym_level(sym_t s);
    case (s)
      2'b00:   return -3'sd3;
      2'b01:   return -3'sd1;
      2'b11:   return 3'sd1;
      default: return 3'sd3;
    endcase
  endfunction
endpackage

// File: rtl/dfe_hist.sv
module dfe_hist #(
  parameter int DEPTH = 17
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  dfe_pkg::sym_t               even_i,
  input  dfe_pkg::sym_t               odd_i,
  output dfe_pkg::sym_t [DEPTH-1:0]   hist_o
);
  dfe_pkg::sym_t [DEPTH-1:0] hist_q;

  // index 0 is newest (odd), index 1 the even of the same pair
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= {hist_q[DEPTH-3:0], even_i, odd_i};
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/dfe_tap.sv
module dfe_tap #(
  parameter int DEPTH   = 17,
  parameter int POS_MIN = 5,
  parameter int POS_MAX = 17,
  parameter int POS_W   = 5,
  parameter int WT_W    = 7,
  parameter int CUR_W   = 10
) (
  input  dfe_pkg::sym_t [DEPTH-1:0] hist_i,
  input  logic [POS_W-1:0]          pos_i,
  input  logic [WT_W-1:0]           wt_i,
  input  logic                      train_i,
  output logic signed [CUR_W-1:0]   cur_even_o,
  output logic signed [CUR_W-1:0]   cur_odd_o
);
  logic [POS_W-1:0]        pos_c;
  logic [POS_W-1:0]        idx_e, idx_o;
  dfe_pkg::sym_t           sel_e, sel_o;
  logic signed [CUR_W-1:0] w_s, lv_e, lv_o;

  always_comb begin
    if (pos_i < POS_W'(POS_MIN))      pos_c = POS_W'(POS_MIN);
    else if (pos_i > POS_W'(POS_MAX)) pos_c = POS_W'(POS_MAX);
    else                              pos_c = pos_i;
  end

  assign idx_e = pos_c - POS_W'(1);
  assign idx_o = pos_c - POS_W'(2);
  assign sel_e = hist_i[idx_e];
  assign sel_o = hist_i[idx_o];

  assign w_s  = $signed({{(CUR_W-WT_W){1'b0}}, wt_i});
  assign lv_e = CUR_W'(dfe_pkg::sym_level(sel_e));
  assign lv_o = CUR_W'(dfe_pkg::sym_level(sel_o));

  always_comb begin
    if (train_i) begin
      cur_even_o = -w_s;
      cur_odd_o  = w_s;
    end else begin
      cur_even_o = lv_e * w_s;
      cur_odd_o  = lv_o * w_s;
    end
  end
endmodule

// File: rtl/dfe_train.sv
module dfe_train #(
  parameter int DLY_W  = 5,
  parameter int VOTE_W = 8,
  parameter int PH_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [VOTE_W-1:0] len_i,
  input  logic              early_i,
  input  logic              late_i,
  input  logic [PH_W-1:0]   phase_i,
  output logic [DLY_W-1:0]  dly_o,
  output logic [PH_W-1:0]   phase_o,
  output logic              active_o,
  output logic              done_o
);
  localparam logic [DLY_W-1:0] DLY_MID = DLY_W'(1) << (DLY_W-1);

  logic [DLY_W-1:0]  dly_q, base_q, dly_nxt;
  logic [VOTE_W-1:0] cnt_q, len_eff;
  logic [PH_W-1:0]   ph_q;
  logic              act_q, done_q, vote;

  assign vote    = early_i ^ late_i;
  assign len_eff = (len_i == '0) ? VOTE_W'(1) : len_i;

  always_comb begin
    dly_nxt = dly_q;
    if (early_i && !late_i && dly_q != '1) dly_nxt = dly_q + DLY_W'(1);
    if (late_i && !early_i && dly_q != '0) dly_nxt = dly_q - DLY_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q  <= DLY_MID;
      base_q <= DLY_MID;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i && !act_q) begin
      act_q  <= 1'b1;
      done_q <= 1'b0;
      base_q <= dly_q;
      cnt_q  <= '0;
    end else if (act_q && vote) begin
      dly_q <= dly_nxt;
      if (cnt_q >= len_eff - VOTE_W'(1)) begin
        cnt_q <= '0;
        if (dly_nxt == base_q) begin
          act_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          base_q <= dly_nxt;
        end
      end else begin
        cnt_q <= cnt_q + VOTE_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ph_q <= '0;
    else if (!act_q) ph_q <= phase_i;
  end

  assign dly_o    = dly_q;
  assign phase_o  = ph_q;
  assign active_o = act_q;
  assign done_o   = done_q;
endmodule

// File: rtl/dfe_tap_ctrl.sv
module dfe_tap_ctrl #(
  parameter int NUM_TAPS = 5,
  parameter int POS_MIN  = 5,
  parameter int POS_MAX  = 17,
  parameter int WT_W     = 7,
  parameter int DLY_W    = 5,
  parameter int VOTE_W   = 8,
  parameter int PH_W     = 6,
  localparam int POS_W   = $clog2(POS_MAX + 1),
  localparam int CUR_W   = WT_W + 3,
  localparam int DEPTH   = POS_MAX
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [1:0]                dec_even_i,
  input  logic [1:0]                dec_odd_i,
  input  logic [NUM_TAPS*POS_W-1:0] tap_pos_i,
  input  logic [NUM_TAPS*WT_W-1:0]  tap_wt_i,
  input  logic                      train_start_i,
  input  logic [VOTE_W-1:0]         train_len_i,
  input  logic                      cdr_early_i,
  input  logic                      cdr_late_i,
  input  logic [PH_W-1:0]           cdr_phase_i,
  output logic [NUM_TAPS*CUR_W-1:0] eq_even_o,
  output logic [NUM_TAPS*CUR_W-1:0] eq_odd_o,
  output logic [DLY_W-1:0]          dly_code_o,
  output logic [PH_W-1:0]           rx_phase_o,
  output logic                      train_active_o,
  output logic                      train_done_o
);
  dfe_pkg::sym_t [DEPTH-1:0] hist;

  dfe_hist #(.DEPTH(DEPTH)) u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .even_i (dec_even_i),
    .odd_i  (dec_odd_i),
    .hist_o (hist)
  );

  dfe_train #(.DLY_W(DLY_W), .VOTE_W(VOTE_W), .PH_W(PH_W)) u_train (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (train_start_i),
    .len_i    (train_len_i),
    .early_i  (cdr_early_i),
    .late_i   (cdr_late_i),
    .phase_i  (cdr_phase_i),
    .dly_o    (dly_code_o),
    .phase_o  (rx_phase_o),
    .active_o (train_active_o),
    .done_o   (train_done_o)
  );

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    logic signed [CUR_W-1:0] ce, co;
    dfe_tap #(
      .DEPTH(DEPTH), .POS_MIN(POS_MIN), .POS_MAX(POS_MAX),
      .POS_W(POS_W), .WT_W(WT_W), .CUR_W(CUR_W)
    ) u_tap (
      .hist_i     (hist),
      .pos_i      (tap_pos_i[k*POS_W +: POS_W]),
      .wt_i       (tap_wt_i[k*WT_W +: WT_W]),
      .train_i    (train_active_o),
      .cur_even_o (ce),
      .cur_odd_o  (co)
    );
    assign eq_even_o[k*CUR_W +: CUR_W] = ce;
    assign eq_odd_o[k*CUR_W +: CUR_W]  = co;
  end
endmodule

// File: rtl/dfe_tap_ctrl_chk.sv
module dfe_tap_ctrl_chk #(
  parameter int NUM_TAPS = 5,
  parameter int CUR_W    = 10,
  parameter int DLY_W    = 5,
  parameter int PH_W     = 6
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      cdr_early_i,
  input logic                      cdr_late_i,
  input logic [DLY_W-1:0]          dly_code_i,
  input logic [PH_W-1:0]           rx_phase_i,
  input logic                      train_active_i,
  input logic                      train_done_i,
  input logic [NUM_TAPS*CUR_W-1:0] eq_even_i,
  input logic [NUM_TAPS*CUR_W-1:0] eq_odd_i
);
  assert_dly_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !train_active_i |=> $stable(dly_code_i));

  assert_dly_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($stable(dly_code_i) || dly_code_i == $past(dly_code_i) + DLY_W'(1)
              || dly_code_i == $past(dly_code_i) - DLY_W'(1)));

  assert_dly_sat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (train_active_i && dly_code_i == '1 && cdr_early_i && !cdr_late_i) |=> dly_code_i == '1);

  assert_phase_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    train_active_i |=> $stable(rx_phase_i));

  assert_done_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(train_active_i && train_done_i));

  assert_done_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(train_done_i) |-> $fell(train_active_i));

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_pat
    assert_train_pat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      train_active_i |-> ($signed(eq_even_i[k*CUR_W +: CUR_W]) ==
                          -$signed(eq_odd_i[k*CUR_W +: CUR_W])));
  end
endmodule

bind dfe_tap_ctrl dfe_tap_ctrl_chk #(
  .NUM_TAPS(NUM_TAPS), .CUR_W(CUR_W), .DLY_W(DLY_W), .PH_W(PH_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cdr_early_i    (cdr_early_i),
  .cdr_late_i     (cdr_late_i),
  .dly_code_i     (dly_code_o),
  .rx_phase_i     (rx_phase_o),
  .train_active_i (train_active_o),
  .train_done_i   (train_done_o),
  .eq_even_i      (eq_even_o),
  .eq_odd_i       (eq_odd_o)
);

// File: tb/dfe_tap_ctrl_test.sv
`timescale 1ns/1ps
module dfe_tap_ctrl_test;
  localparam int NT = 5;
  localparam int CW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    dec_even = '0, dec_odd = '0;
  logic [24:0]   tap_pos = '0;
  logic [34:0]   tap_wt = '0;
  logic          start = 1'b0;
  logic [7:0]    tlen = '0;
  logic          early = 1'b0, late = 1'b0;
  logic [5:0]    phase_in = '0;
  logic [NT*CW-1:0] eq_even, eq_odd;
  logic [4:0]    dly;
  logic [5:0]    rx_phase;
  logic          active, done;

  always #4 clk = ~clk;

  dfe_tap_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .dec_even_i(dec_even), .dec_odd_i(dec_odd),
    .tap_pos_i(tap_pos), .tap_wt_i(tap_wt), .train_start_i(start),
    .train_len_i(tlen), .cdr_early_i(early), .cdr_late_i(late),
    .cdr_phase_i(phase_in), .eq_even_o(eq_even), .eq_odd_o(eq_odd),
    .dly_code_o(dly), .rx_phase_o(rx_phase), .train_active_o(active),
    .train_done_o(done)
  );

  typedef struct {
    logic [NT*CW-1:0] ee, eo;
    logic [4:0]       dl;
    logic [5:0]       ph;
    logic             ac, dn;
    string            tag;
  } item_t;

  item_t q[$];
  int n_vec = 0, n_bad = 0;

  // reference model state
  int hist_m[17];
  int pos_m[NT], wt_m[NT];
  int dly_m = 16, base_m = 16, cnt_m = 0, ph_m = 0;
  bit act_m = 0, done_m = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int lvl(int s);
    case (s)
      0: return -3;
      1: return -1;
      3: return 1;
      default: return 3;
    endcase
  endfunction

  function automatic int clampp(int p);
    if (p < 5) return 5;
    if (p > 17) return 17;
    return p;
  endfunction

  function automatic item_t expect_now(string tag);
    item_t it;
    for (int k = 0; k < NT; k++) begin
      int d = clampp(pos_m[k]);
      int ve, vo;
      if (act_m) begin
        ve = -wt_m[k]; vo = wt_m[k];
      end else begin
        ve = lvl(hist_m[d-1]) * wt_m[k];
        vo = lvl(hist_m[d-2]) * wt_m[k];
      end
      it.ee[k*CW +: CW] = CW'(ve);
      it.eo[k*CW +: CW] = CW'(vo);
    end
    it.dl = 5'(dly_m); it.ph = 6'(ph_m);
    it.ac = act_m; it.dn = done_m; it.tag = tag;
    return it;
  endfunction

  task automatic compare(item_t it);
    bit bad = 0;
    n_vec++;
    if (eq_even !== it.ee) begin bad = 1; $display("FAIL %s eq_even act=%h exp=%h", it.tag, eq_even, it.ee); end
    if (eq_odd !== it.eo) begin bad = 1; $display("FAIL %s eq_odd act=%h exp=%h", it.tag, eq_odd, it.eo); end
    if (dly !== it.dl) begin bad = 1; $display("FAIL %s dly act=%0d exp=%0d", it.tag, dly, it.dl); end
    if (rx_phase !== it.ph) begin bad = 1; $display("FAIL %s phase act=%0d exp=%0d", it.tag, rx_phase, it.ph); end
    if (active !== it.ac) begin bad = 1; $display("FAIL %s active act=%b exp=%b", it.tag, active, it.ac); end
    if (done !== it.dn) begin bad = 1; $display("FAIL %s done act=%b exp=%b", it.tag, done, it.dn); end
    if (bad) n_bad++;
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) compare(q.pop_front());
  end

  task automatic set_taps(input int p0, p1, p2, p3, p4, input int w0, w1, w2, w3, w4);
    int pp[NT] = '{p0, p1, p2, p3, p4};
    int ww[NT] = '{w0, w1, w2, w3, w4};
    for (int k = 0; k < NT; k++) begin
      pos_m[k] = pp[k]; wt_m[k] = ww[k];
      tap_pos[k*5 +: 5] = 5'(pp[k]);
      tap_wt[k*7 +: 7]  = 7'(ww[k]);
    end
  endtask

  // driver: one clock, pushes expected state after the edge
  task automatic cyc(input int ev, od, input bit e, l, st, input int ph, input string tag);
    bit old_act;
    @(negedge clk);
    dec_even = 2'(ev); dec_odd = 2'(od);
    early = e; late = l; start = st; phase_in = 6'(ph);
    old_act = act_m;
    if (!old_act) ph_m = ph;
    if (st && !old_act) begin
      act_m = 1; done_m = 0; base_m = dly_m; cnt_m = 0;
    end else if (old_act && (e ^ l)) begin
      int nx = dly_m;
      int ln = (tlen == 0) ? 1 : int'(tlen);
      if (e && nx < 31) nx++;
      if (l && nx > 0) nx--;
      if (cnt_m + 1 >= ln) begin
        cnt_m = 0;
        if (nx == base_m) begin act_m = 0; done_m = 1; end
        else base_m = nx;
      end else cnt_m++;
      dly_m = nx;
    end
    for (int j = 16; j >= 2; j--) hist_m[j] = hist_m[j-2];
    hist_m[1] = ev; hist_m[0] = od;
    q.push_back(expect_now(tag));
    @(posedge clk);
    #3;
  endtask

  task automatic rnd_pair(output int a, b);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    a = int'(lfsr[1:0]); b = int'(lfsr[3:2]);
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int a, b, ph;
    ph = 0;
    for (int j = 0; j < 17; j++) hist_m[j] = 0;
    set_taps(5, 9, 12, 16, 17, 1, 2, 3, 4, 5);
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state, history of 00 gives -3*weight
    compare(expect_now("R10 reset"));
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #3;
    compare(expect_now("R10 post-reset"));

    // R1 R2 R3 R4: non-sequential taps, pseudo-random symbols
    set_taps(12, 5, 17, 9, 16, 127, 1, 64, 33, 90);
    for (int i = 0; i < 40; i++) begin
      rnd_pair(a, b);
      cyc(a, b, 0, 0, 0, ph++, "R1 R2 R3 R4 lanes");
    end
    // R3: each code value on every lane
    for (int i = 0; i < 4; i++)
      for (int r = 0; r < 10; r++) cyc(i, 3 - i, 0, 0, 0, ph++, "R3 level map");

    // R5: out-of-range positions clamp
    set_taps(0, 3, 20, 31, 4, 7, 11, 13, 17, 19);
    for (int i = 0; i < 24; i++) begin
      rnd_pair(a, b);
      cyc(a, b, 0, 0, 0, ph++, "R5 clamp");
    end

    // R7 R8: votes ignored outside training, phase follows
    for (int i = 0; i < 8; i++) cyc(1, 2, i[0], ~i[0], 0, ph++, "R7 R8 idle votes");

    // R9 R6 R7 R8: climb to upper rail, converge there
    set_taps(6, 8, 10, 14, 15, 10, 20, 30, 40, 50);
    tlen = 8'd4;
    cyc(0, 1, 0, 0, 1, ph++, "R9 start");
    for (int i = 0; i < 60 && act_m; i++) begin
      rnd_pair(a, b);
      cyc(a, b, 1, 0, 0, ph++, "R6 R7 R8 train up");
    end
    cyc(2, 2, 0, 0, 0, ph++, "R9 done high");
    cyc(3, 1, 0, 0, 0, ph++, "R8 phase resumes");

    // R9: alternating votes, no net change in window
    cyc(0, 0, 0, 0, 1, ph++, "R9 start alt");
    for (int i = 0; i < 20 && act_m; i++) begin
      cyc(1, 3, 0, 0, 0, ph++, "R7 no vote");
      cyc(2, 0, 1, 1, 0, ph++, "R7 both vote");
      cyc(3, 2, i[0], ~i[0], 0, ph++, "R9 alt vote");
    end
    cyc(0, 1, 0, 0, 0, ph++, "R9 done alt");

    // R7 R9: fall to lower rail
    tlen = 8'd6;
    cyc(1, 1, 0, 0, 1, ph++, "R9 start down");
    for (int i = 0; i < 80 && act_m; i++) begin
      rnd_pair(a, b);
      cyc(a, b, 0, 1, 0, ph++, "R7 train down");
    end
    cyc(2, 3, 0, 0, 0, ph++, "R9 done low");

    // R9: zero window length acts as one
    tlen = 8'd0;
    cyc(0, 2, 0, 0, 1, ph++, "R9 start len0");
    cyc(1, 0, 0, 1, 0, ph++, "R9 len0 vote");
    cyc(3, 3, 0, 0, 0, ph++, "R9 len0 done");

    repeat (2) @(posedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule